// File: doc/BRIEF.md
# Double-Column Hit Priority Encoder

This block performs the digital readout of one double column of binary pixel hits. A frame of hit flags is taken into a bank of per-pixel latches when a frame strobe arrives. A tree of identical four-input cells then selects one pending hit. Each cell forms an OR of its four requests, encodes the winning input as two address bits, and steers a clear pulse back to that input only. The address bits of all tree levels together give the pixel index.

The region logic issues one read per clock. A read that finds a pending hit returns that pixel's index on the registered output, with a one-cycle valid pulse. In the same clock edge the clear pulse travels down the tree and empties that pixel's latch, so the next hit comes up for the following read. Hits drain one per cycle in ascending index order. New hit data on the input is ignored until the next strobe, so the column can collect the following frame while the current one is read out.

Top module: `dcol_prio_enc`

## Requirements
- R1: After a synchronous active-high reset, `valid_o` and `addr_o` are 0 and all latches are empty, so a read made before any strobe gives no address.
- R2: A cycle with `frame_strobe_i` high loads every latch from `hit_i`. Hits still pending from the previous frame are discarded.
- R3: Changes on `hit_i` in cycles without a strobe have no effect on the latched frame.
- R4: A read (`rd_en_i` high, strobe low) made while hits are pending raises `valid_o` for exactly the next cycle. `addr_o` then carries the index (0 to NPIX-1) of the lowest-numbered pending pixel.
- R5: The reported pixel is cleared by the same edge. Back-to-back reads return each latched hit exactly once, one per cycle, in strictly ascending index order.
- R6: In a cycle with neither read nor strobe, `valid_o` is low in the following cycle and the latched frame is unchanged.
- R7: A read made when no hit is pending leaves `valid_o` low and emits no address.
- R8: When strobe and read are high in the same cycle, the frame is loaded, the read is dropped and `valid_o` stays low.
- R9: The end pixels 0 and NPIX-1 are reported correctly. A completely full column drains in exactly NPIX reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NPIX | Discriminated hit flag per pixel, bit i is pixel i |
| frame_strobe_i | input | 1 | Loads `hit_i` into the latches |
| rd_en_i | input | 1 | Read request from the region logic |
| addr_o | output | ADDR_W | Index of the reported pixel |
| valid_o | output | 1 | One-cycle pulse marking a reported address |

## Verification
The bench aims at the places where a priority tree usually breaks. If the address bits of a tree level are misplaced, the output order stops ascending or pixel indices come out shifted. If the clear pulse is steered to the wrong child, a hit is reported twice or is lost. If the end pixels 0 and 1007 fall outside the tree, a full column does not drain in NPIX reads. The bench also checks a strobe arriving alongside a read (a design that favours the read emits a stale address), a reload while hits are still pending (leftover hits would leak into the new frame), input changes without a strobe (a transparent latch would pick them up), and reads of an empty column (a design that reports them emits a spurious address).

// File: rtl/dcpe_pkg.sv
package dcpe_pkg;
  // number of 4-way levels needed to cover n leaves
  function automatic int tree_levels(input int n);
    int lv;
    int cap;
    lv = 1;
    cap = 4;
    while (cap < n) begin
      lv++;
      cap = cap * 4;
    end
    return lv;
  endfunction
endpackage

// File: rtl/dcpe_cell.sv
module dcpe_cell (
  input  logic [3:0] req,
  input  logic       clr_in,
  output logic       any,
  output logic [1:0] sel,
  output logic [3:0] clr_out
);
  always_comb begin
    any = |req;
    casez (req)
      4'b???1: sel = 2'd0;
      4'b??10: sel = 2'd1;
      4'b?100: sel = 2'd2;
      default: sel = 2'd3;
    endcase
    clr_out = (clr_in && any) ? (4'b0001 << sel) : 4'b0000;
  end
endmodule

// File: rtl/dcpe_latch.sv
module dcpe_latch #(
  parameter int N = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] din,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
    else           q <= q & ~clr;
  end
endmodule

// File: rtl/dcpe_tree.sv
module dcpe_tree #(
  parameter int LEVELS = 5,
  parameter int ADDR_W = 2 * LEVELS,
  localparam int NLEAF = 4 ** LEVELS
) (
  input  logic [NLEAF-1:0]  req,
  input  logic              clr_in,
  output logic              any,
  output logic [ADDR_W-1:0] addr,
  output logic [NLEAF-1:0]  clr
);
  localparam int NNODE = (NLEAF - 1) / 3;
  localparam int TOT   = NNODE + NLEAF;

  // heap layout: node n has children 4n+1 .. 4n+4, leaves follow the inner nodes
  logic [TOT-1:0]    vld;
  logic [TOT-1:0]    clr_n;
  logic [ADDR_W-1:0] an [NNODE];

  assign vld[TOT-1:NNODE] = req;
  assign clr_n[0]         = clr_in;
  assign clr              = clr_n[TOT-1:NNODE];
  assign any              = vld[0];
  assign addr             = an[0];

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    for (genvar k = 0; k < 4 ** d; k++) begin : g_cell
      localparam int NODE = (4 ** d - 1) / 3 + k;
      localparam int CH   = 4 * NODE + 1;
      localparam int HT   = LEVELS - d;
      logic [1:0] sel;
      dcpe_cell u_cell (
        .req     (vld[CH+3:CH]),
        .clr_in  (clr_n[NODE]),
        .any     (vld[NODE]),
        .sel     (sel),
        .clr_out (clr_n[CH+3:CH])
      );
      if (HT > 1) begin : g_inner
        assign an[NODE] = an[CH + int'(sel)] | (ADDR_W'(sel) << (2 * (HT - 1)));
      end else begin : g_leafcell
        assign an[NODE] = ADDR_W'(sel);
      end
    end
  end
endmodule

// File: rtl/dcol_prio_enc.sv
module dcol_prio_enc #(
  parameter int NPIX = 1008,
  localparam int LEVELS = dcpe_pkg::tree_levels(NPIX),
  localparam int ADDR_W = 2 * LEVELS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIX-1:0]   hit_i,
  input  logic              frame_strobe_i,
  input  logic              rd_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  localparam int NLEAF = 4 ** LEVELS;

  logic [NLEAF-1:0]  hit_pad;
  logic [NLEAF-1:0]  hits_q;
  logic [NLEAF-1:0]  pix_clr;
  logic              tree_any;
  logic [ADDR_W-1:0] tree_addr;
  logic              clr_req;

  if (NLEAF > NPIX) begin : g_pad
    assign hit_pad = {{(NLEAF-NPIX){1'b0}}, hit_i};
  end else begin : g_nopad
    assign hit_pad = hit_i;
  end

  // strobe wins over a read in the same cycle (R8)
  assign clr_req = rd_en_i && !frame_strobe_i && tree_any;

  dcpe_latch #(.N(NLEAF)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (frame_strobe_i),
    .din  (hit_pad),
    .clr  (pix_clr),
    .q    (hits_q)
  );

  dcpe_tree #(.LEVELS(LEVELS), .ADDR_W(ADDR_W)) u_tree (
    .req    (hits_q),
    .clr_in (clr_req),
    .any    (tree_any),
    .addr   (tree_addr),
    .clr    (pix_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= clr_req;
      if (clr_req) addr_o <= tree_addr;
    end
  end

  // R2
  load_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(frame_strobe_i)) |-> hits_q[NPIX-1:0] == $past(hit_i));

  // R4
  emit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (!$past(rst) && $past(rd_en_i) && !$past(frame_strobe_i)));

  // R5
  cleared_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !hits_q[addr_o]);

  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o)) |-> addr_o > $past(addr_o));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(frame_strobe_i) && !$past(rd_en_i)) |-> $stable(hits_q));

  // R7
  empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hits_q) == '0 && !$past(frame_strobe_i)) |-> !valid_o);
endmodule

// File: tb/tb_dcol_prio_enc.sv
module tb_dcol_prio_enc;
  localparam int CLK_P = 10;
  localparam int NPIX  = 1008;
  localparam int AW    = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIX-1:0] hit_i = '0;
  logic            frame_strobe_i = 1'b0;
  logic            rd_en_i = 1'b0;
  logic [AW-1:0]   addr_o;
  logic            valid_o;

  int checks = 0;
  int fails  = 0;
  logic [NPIX-1:0] model = '0;
  logic [NPIX-1:0] hv;
  logic [31:0]     lfsr = 32'h1D2C3B4A;
  bit              qv[$];
  logic [AW-1:0]   qa[$];
  string           qt[$];

  dcol_prio_enc #(.NPIX(NPIX)) dut (
    .clk(clk), .rst(rst), .hit_i(hit_i), .frame_strobe_i(frame_strobe_i),
    .rd_en_i(rd_en_i), .addr_o(addr_o), .valid_o(valid_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input bit stb, input bit rd, input logic [NPIX-1:0] v, input string tag);
    int idx;
    bit ev;
    @(negedge clk);
    frame_strobe_i = stb;
    rd_en_i = rd;
    hit_i = v;
    ev = 1'b0;
    idx = 0;
    if (stb) model = v;
    else if (rd) begin
      for (int i = NPIX - 1; i >= 0; i--) if (model[i]) begin idx = i; ev = 1'b1; end
      if (ev) model[idx] = 1'b0;
    end
    qv.push_back(ev);
    qa.push_back(AW'(idx));
    qt.push_back(tag);
  endtask

  task automatic drain(input string tag);
    int n;
    n = $countones(model) + 1;
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, hit_i, tag);
  endtask

  // monitor: compares each output cycle against the scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst && qv.size() > 0) begin
      bit ev;
      logic [AW-1:0] ea;
      string t;
      ev = qv.pop_front();
      ea = qa.pop_front();
      t  = qt.pop_front();
      if (valid_o !== ev) check(1'b0, {t, " valid"}, int'(valid_o), int'(ev));
      else if (ev && addr_o !== ea) check(1'b0, {t, " addr"}, int'(addr_o), int'(ea));
      else check(1'b1, t, 0, 0);
    end
  end

  initial begin
    #(CLK_P * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(addr_o == '0, "R1 addr in reset", int'(addr_o), 0);
    rst = 1'b0;
    step(1'b0, 1'b1, '0, "R1");
    step(1'b0, 1'b1, '0, "R1");

    // scattered frame including both end pixels
    hv = '0; hv[5] = 1; hv[3] = 1; hv[900] = 1; hv[0] = 1; hv[NPIX-1] = 1;
    step(1'b1, 1'b0, hv, "R2");
    step(1'b0, 1'b1, hv, "R4");
    step(1'b0, 1'b1, hv, "R5");
    step(1'b0, 1'b1, hv, "R5");
    step(1'b0, 1'b1, hv, "R5");
    step(1'b0, 1'b1, hv, "R9");
    step(1'b0, 1'b1, hv, "R7");

    // input changes without a strobe are ignored
    hv = '0; hv[10] = 1;
    step(1'b1, 1'b0, hv, "R2");
    hv = '0; hv[2] = 1; hv[11] = 1;
    step(1'b0, 1'b0, hv, "R6");
    step(1'b0, 1'b0, hv, "R3");
    step(1'b0, 1'b1, hv, "R3");
    step(1'b0, 1'b1, hv, "R3");

    // reload discards leftovers
    hv = '0; hv[1] = 1; hv[2] = 1; hv[3] = 1;
    step(1'b1, 1'b0, hv, "R2");
    step(1'b0, 1'b1, hv, "R4");
    hv = '0; hv[50] = 1;
    step(1'b1, 1'b0, hv, "R2");
    step(1'b0, 1'b1, hv, "R2");
    step(1'b0, 1'b1, hv, "R2");

    // strobe and read in one cycle
    hv = '0; hv[7] = 1;
    step(1'b1, 1'b1, hv, "R8");
    step(1'b0, 1'b1, hv, "R8");
    step(1'b0, 1'b1, hv, "R7");

    // idle cycles between reads
    hv = '0; hv[20] = 1; hv[21] = 1;
    step(1'b1, 1'b0, hv, "R2");
    step(1'b0, 1'b1, hv, "R4");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, hv, "R6");
    step(1'b0, 1'b1, hv, "R6");
    step(1'b0, 1'b1, hv, "R7");

    // full column
    step(1'b1, 1'b0, '1, "R9");
    drain("R9");

    // pseudo-random frames
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NPIX; i++) begin
        hv[i] = (lfsr[2:0] == 3'b000);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      end
      step(1'b1, 1'b0, hv, "R2");
      drain("R5");
    end

    @(negedge clk);
    rd_en_i = 1'b0;
    frame_strobe_i = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule